// File: doc/BRIEF.md
# Multicycle Execution Issue Interlock

This block sits at the issue point of an in-order, single-issue pipeline that feeds four execution units of unequal depth: a one-cycle integer unit, a pipelined floating-point adder, a pipelined multiplier and a divider that is not pipelined. Each cycle it is offered at most one decoded instruction. The instruction carries its unit class, its destination register with a write flag, and up to two source registers, each with an enable. The block answers in the same cycle whether the instruction issues or stalls, and why it stalls. Full forwarding is assumed, so a result can be used exactly "latency" cycles after its producer would otherwise have been followed back to back.

The block keeps three pieces of state. A countdown per architectural register gives the number of cycles until its newest pending value can be forwarded. An occupancy counter per non-pipelined unit enforces that unit's initiation interval. A reservation line models the single memory/writeback slot that every instruction passes through, so that two instructions never reach it in the same cycle. When an issued instruction reaches that slot, the block reports a completion event carrying the destination tag. Operand values are never read at issue, so write-after-read needs no check. Only read-after-write, write-after-write, unit occupancy and slot collisions can hold an instruction back.

Top module: `fp_issue_lock`

## Requirements
- R1: While `in_valid` is low, and right after reset, `issue` and `stall` are low and `stall_why` is 0 (none); no completion is reported after reset until something issues.
- R2: Unit code 0 (integer) has latency 0: an integer instruction that reads the destination of an integer instruction issued in the previous cycle issues without a stall.
- R3: A consumer of a result stalls exactly the producer's latency when offered in the cycle after the producer issues: 3 cycles for unit code 1 (adder), 6 for unit code 2 (multiplier), 24 for unit code 3 (divider).
- R4: An instruction that writes a register is held with reason WAW while its completion cycle would be at or before the completion cycle of an older pending write to the same register.
- R5: The divider (unit code 3) accepts a new instruction only 25 cycles after the previous one. A divide offered in the cycle after another divide stalls 24 cycles with reason UNIT.
- R6: Adder and multiplier instructions with no dependences issue in consecutive cycles without stalling.
- R7: When a new instruction would reach the memory/writeback slot in the same cycle as an instruction already in flight, the new one stalls with reason SLOT; the in-flight instruction keeps its completion cycle.
- R8: `stall_why` encodes 0 none, 1 RAW, 2 WAW, 3 UNIT (busy unit), 4 SLOT, with priority RAW over WAW over UNIT over SLOT; it is nonzero exactly when `stall` is high.
- R9: An instruction with latency L issued in cycle t raises `done_valid` in cycle t+L+1, with `done_tag` equal to its destination and `done_wr` equal to its write flag.
- R10: A source register whose enable is low causes no RAW stall, whatever its index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is offered this cycle |
| in_unit | input | 2 | Unit class: 0 integer, 1 adder, 2 multiplier, 3 divider |
| in_dst | input | REG_W | Destination register |
| in_dst_we | input | 1 | Instruction writes its destination |
| in_src1 | input | REG_W | First source register |
| in_s1_en | input | 1 | First source is read |
| in_src2 | input | REG_W | Second source register |
| in_s2_en | input | 1 | Second source is read |
| issue | output | 1 | Offered instruction issues this cycle |
| stall | output | 1 | Offered instruction is held this cycle |
| stall_why | output | 3 | Reason for the stall (R8 encoding) |
| done_valid | output | 1 | An issued instruction reaches the memory/writeback slot |
| done_tag | output | REG_W | Destination of the completing instruction |
| done_wr | output | 1 | Completing instruction writes its destination |

## Verification
The properties assume that an instruction held in a stall is offered again unchanged, and that the unit code, destination and sources are stable and known whenever `in_valid` is high. The divider spacing and back-to-back dependence properties also assume that an issued instruction is not offered a second time. The directed tasks meet this by holding each instruction until `issue` rises and by driving inputs only at the falling edge. Every scenario ends with an idle drain long enough for the divider, so no test inherits pending state from the one before it.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

   localparam int NUM_UNITS = 4;

   typedef enum logic [1:0] {
      U_INT = 2'd0,
      U_ADD = 2'd1,
      U_MUL = 2'd2,
      U_DIV = 2'd3
   } unit_e;

   typedef enum logic [2:0] {
      WHY_NONE = 3'd0,
      WHY_RAW  = 3'd1,
      WHY_WAW  = 3'd2,
      WHY_UNIT = 3'd3,
      WHY_SLOT = 3'd4
   } why_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/fpil_ready_table.sv
// Per-register countdown: cycles until the newest pending value can be forwarded.
module fpil_ready_table #(
   parameter int REG_W = 5,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_lat,
   input  logic [REG_W-1:0] rd_a,
   input  logic [REG_W-1:0] rd_b,
   input  logic [REG_W-1:0] rd_c,
   output logic [CNT_W-1:0] cnt_a,
   output logic [CNT_W-1:0] cnt_b,
   output logic [CNT_W-1:0] cnt_c
);
   localparam int NREGS = 1 << REG_W;

   logic [CNT_W-1:0] cnt_q [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGS; r++) cnt_q[r] <= '0;
      end else begin
         for (int r = 0; r < NREGS; r++) begin
            if (wr_en && (wr_idx == REG_W'(r)))
               cnt_q[r] <= wr_lat;
            else if (cnt_q[r] != '0)
               cnt_q[r] <= cnt_q[r] - CNT_W'(1);
         end
      end
   end

   assign cnt_a = cnt_q[rd_a];
   assign cnt_b = cnt_q[rd_b];
   assign cnt_c = cnt_q[rd_c];

endmodule

// File: rtl/fpil_unit_gate.sv
// Occupancy per execution unit; only units with an initiation interval above 1 get a counter.
module fpil_unit_gate #(
   parameter int II_INT = 1,
   parameter int II_ADD = 1,
   parameter int II_MUL = 1,
   parameter int II_DIV = 25
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic [1:0] fire_unit,
   output logic [3:0] busy
);
   import fpil_pkg::*;

   localparam int II_TAB [NUM_UNITS] = '{II_INT, II_ADD, II_MUL, II_DIV};
   localparam int II_MAX = max4(II_INT, II_ADD, II_MUL, II_DIV);
   localparam int II_W   = $clog2(II_MAX + 1);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      if (II_TAB[u] > 1) begin : g_blocking
         logic [II_W-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (fire && (fire_unit == 2'(u)))
               left_q <= II_W'(II_TAB[u] - 1);
            else if (left_q != '0)
               left_q <= left_q - II_W'(1);
         end
         assign busy[u] = (left_q != '0);
      end else begin : g_pipelined
         assign busy[u] = 1'b0;
      end
   end

endmodule

// File: rtl/fpil_wb_slot.sv
// Reservation line for the shared memory/writeback slot; entry 0 completes this cycle.
module fpil_wb_slot #(
   parameter int REG_W   = 5,
   parameter int MAX_LAT = 24,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             put,
   input  logic [CNT_W-1:0] put_lat,
   input  logic [REG_W-1:0] put_tag,
   input  logic             put_wr,
   input  logic [CNT_W-1:0] ask_lat,
   output logic             clash,
   output logic             done_valid,
   output logic [REG_W-1:0] done_tag,
   output logic             done_wr
);
   localparam int SLOTS = MAX_LAT + 2;

   logic             v_q   [SLOTS];
   logic [REG_W-1:0] tag_q [SLOTS];
   logic             wr_q  [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) begin
            v_q[k]   <= 1'b0;
            tag_q[k] <= '0;
            wr_q[k]  <= 1'b0;
         end
      end else begin
         for (int k = 0; k < SLOTS - 1; k++) begin
            v_q[k]   <= v_q[k+1];
            tag_q[k] <= tag_q[k+1];
            wr_q[k]  <= wr_q[k+1];
         end
         v_q[SLOTS-1]   <= 1'b0;
         tag_q[SLOTS-1] <= '0;
         wr_q[SLOTS-1]  <= 1'b0;
         for (int k = 0; k < SLOTS; k++) begin
            if (put && (put_lat == CNT_W'(k))) begin
               v_q[k]   <= 1'b1;
               tag_q[k] <= put_tag;
               wr_q[k]  <= put_wr;
            end
         end
      end
   end

   // Entry at index L+1 now would sit where a new latency-L entry lands after the shift.
   assign clash      = v_q[ask_lat + CNT_W'(1)];
   assign done_valid = v_q[0];
   assign done_tag   = tag_q[0];
   assign done_wr    = wr_q[0];

endmodule

// File: rtl/fp_issue_lock.sv
module fp_issue_lock
   import fpil_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter int LAT_INT = 0,
   parameter int LAT_ADD = 3,
   parameter int LAT_MUL = 6,
   parameter int LAT_DIV = 24,
   parameter int II_INT  = 1,
   parameter int II_ADD  = 1,
   parameter int II_MUL  = 1,
   parameter int II_DIV  = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_unit,
   input  logic [REG_W-1:0] in_dst,
   input  logic             in_dst_we,
   input  logic [REG_W-1:0] in_src1,
   input  logic             in_s1_en,
   input  logic [REG_W-1:0] in_src2,
   input  logic             in_s2_en,
   output logic             issue,
   output logic             stall,
   output logic [2:0]       stall_why,
   output logic             done_valid,
   output logic [REG_W-1:0] done_tag,
   output logic             done_wr
);
   localparam int MAX_LAT = max4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
   localparam int CNT_W   = $clog2(MAX_LAT + 2);
   localparam int LAT_TAB [NUM_UNITS] = '{LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV};

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("fp_issue_lock: REG_W out of range");
   end
   if (LAT_INT < 0 || LAT_ADD < 0 || LAT_MUL < 0 || LAT_DIV < 0) begin : g_bad_lat
      $error("fp_issue_lock: negative latency");
   end
   if (II_INT < 1 || II_ADD < 1 || II_MUL < 1 || II_DIV < 1) begin : g_bad_ii
      $error("fp_issue_lock: initiation interval below 1");
   end

   logic [CNT_W-1:0] cur_lat;
   logic [CNT_W-1:0] cnt_s1, cnt_s2, cnt_dst;
   logic [3:0]       unit_busy;
   logic             slot_clash;
   logic             raw_hit, waw_hit;
   why_e             why;

   always_comb cur_lat = CNT_W'(LAT_TAB[in_unit]);

   fpil_ready_table #(.REG_W(REG_W), .CNT_W(CNT_W)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (issue && in_dst_we),
      .wr_idx (in_dst),
      .wr_lat (cur_lat),
      .rd_a   (in_src1),
      .rd_b   (in_src2),
      .rd_c   (in_dst),
      .cnt_a  (cnt_s1),
      .cnt_b  (cnt_s2),
      .cnt_c  (cnt_dst)
   );

   fpil_unit_gate #(
      .II_INT(II_INT), .II_ADD(II_ADD), .II_MUL(II_MUL), .II_DIV(II_DIV)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (issue),
      .fire_unit (in_unit),
      .busy      (unit_busy)
   );

   fpil_wb_slot #(.REG_W(REG_W), .MAX_LAT(MAX_LAT), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .put        (issue),
      .put_lat    (cur_lat),
      .put_tag    (in_dst),
      .put_wr     (in_dst_we),
      .ask_lat    (cur_lat),
      .clash      (slot_clash),
      .done_valid (done_valid),
      .done_tag   (done_tag),
      .done_wr    (done_wr)
   );

   // Operand not yet forwardable.
   assign raw_hit = (in_s1_en && (cnt_s1 != '0)) || (in_s2_en && (cnt_s2 != '0));
   // Older write to the same register would complete at or after this one.
   assign waw_hit = in_dst_we && (cur_lat < cnt_dst);

   always_comb begin
      why = WHY_NONE;
      if (in_valid) begin
         if (raw_hit)                why = WHY_RAW;
         else if (waw_hit)           why = WHY_WAW;
         else if (unit_busy[in_unit]) why = WHY_UNIT;
         else if (slot_clash)        why = WHY_SLOT;
      end
   end

   assign issue     = in_valid && (why == WHY_NONE);
   assign stall     = in_valid && (why != WHY_NONE);
   assign stall_why = why;

endmodule

// File: rtl/fpil_chk.sv
module fpil_chk #(
   parameter int REG_W  = 5,
   parameter int II_DIV = 25
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_unit,
   input logic [REG_W-1:0] in_dst,
   input logic             in_dst_we,
   input logic [REG_W-1:0] in_src1,
   input logic             in_s1_en,
   input logic             issue,
   input logic             stall,
   input logic [2:0]       stall_why,
   input logic             done_valid,
   input logic [REG_W-1:0] done_tag
);
   localparam int GW = $clog2(II_DIV + 1);

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= GW'(II_DIV);
      else if (issue && (in_unit == 2'd3))
         gap_q <= GW'(1);
      else if (gap_q < GW'(II_DIV))
         gap_q <= gap_q + GW'(1);
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!issue && !stall && (stall_why == 3'd0))); // R1

   AST_INT_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (in_unit == 2'd0)) |=> (done_valid && (done_tag == $past(in_dst)))); // R9

   AST_WHY_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (!stall && (stall_why == 3'd0))); // R8

   AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (in_unit == 2'd3)) |-> (gap_q >= GW'(II_DIV))); // R5

   AST_MUL_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_s1_en && $past(issue && (in_unit == 2'd2) && in_dst_we)
       && (in_src1 == $past(in_dst))) |-> !issue); // R3

endmodule

bind fp_issue_lock fpil_chk #(.REG_W(REG_W), .II_DIV(II_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_unit    (in_unit),
   .in_dst     (in_dst),
   .in_dst_we  (in_dst_we),
   .in_src1    (in_src1),
   .in_s1_en   (in_s1_en),
   .issue      (issue),
   .stall      (stall),
   .stall_why  (stall_why),
   .done_valid (done_valid),
   .done_tag   (done_tag)
);

// File: tb/sim_fp_issue_lock.sv
`timescale 1ns/1ps
module sim_fp_issue_lock;

   localparam logic [1:0] UI = 2'd0, UA = 2'd1, UM = 2'd2, UD = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_unit = 2'd0;
   logic [4:0] in_dst = 5'd0;
   logic       in_dst_we = 1'b0;
   logic [4:0] in_src1 = 5'd0;
   logic       in_s1_en = 1'b0;
   logic [4:0] in_src2 = 5'd0;
   logic       in_s2_en = 1'b0;
   logic       issue, stall, done_valid, done_wr;
   logic [2:0] stall_why;
   logic [4:0] done_tag;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   fp_issue_lock u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
      .in_dst(in_dst), .in_dst_we(in_dst_we), .in_src1(in_src1), .in_s1_en(in_s1_en),
      .in_src2(in_src2), .in_s2_en(in_s2_en), .issue(issue), .stall(stall),
      .stall_why(stall_why), .done_valid(done_valid), .done_tag(done_tag), .done_wr(done_wr)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] u, input logic [4:0] d, input logic we,
                        input logic [4:0] a, input logic ae, input logic [4:0] b, input logic be);
      @(negedge clk);
      in_valid = v; in_unit = u; in_dst = d; in_dst_we = we;
      in_src1 = a; in_s1_en = ae; in_src2 = b; in_s2_en = be;
      #1;
   endtask

   task automatic idle();
      drive(1'b0, UI, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
   endtask

   task automatic drain();
      repeat (30) idle();
   endtask

   // Offer one instruction until it issues; report stall count and first reason.
   task automatic hold(input logic [1:0] u, input logic [4:0] d, input logic we,
                       input logic [4:0] a, input logic ae,
                       output int stalls, output int first_why);
      stalls = 0;
      first_why = 0;
      for (int i = 0; i < 60; i++) begin
         drive(1'b1, u, d, we, a, ae, 5'd0, 1'b0);
         if (issue) break;
         if (stalls == 0) first_why = int'(stall_why);
         stalls++;
      end
   endtask

   task automatic t_reset();
      idle();
      check("R1 issue idle", int'(issue), 0);
      check("R1 stall idle", int'(stall), 0);
      check("R1 why idle", int'(stall_why), 0);
      check("R1 no done after reset", int'(done_valid), 0);
   endtask

   task automatic t_int_chain();
      drive(1'b1, UI, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R2 int producer issues", int'(issue), 1);
      drive(1'b1, UI, 5'd2, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0);
      check("R2 int consumer back to back", int'(issue), 1);
      check("R9 int done valid", int'(done_valid), 1);
      check("R9 int done tag", int'(done_tag), 1);
      idle();
      check("R9 second int done tag", int'(done_tag), 2);
      drain();
   endtask

   task automatic t_raw(input logic [1:0] u, input logic [4:0] tag, input int lat);
      int s, w;
      drive(1'b1, u, tag, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R3 producer issues", int'(issue), 1);
      hold(UI, 5'd31, 1'b1, tag, 1'b1, s, w);
      check("R3 RAW stall cycles", s, lat);
      check("R8 RAW reason", w, 1);
      check("R9 producer completes at consumer issue", int'(done_valid && done_tag == tag), 1);
      drain();
   endtask

   task automatic t_waw();
      int s, w;
      drive(1'b1, UM, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      hold(UA, 5'd5, 1'b1, 5'd0, 1'b0, s, w);
      check("R4 WAW stall cycles", s, 3);
      check("R4 WAW reason", w, 2);
      drain();
   endtask

   task automatic t_div_busy();
      int s, w;
      drive(1'b1, UD, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      hold(UD, 5'd11, 1'b1, 5'd0, 1'b0, s, w);
      check("R5 divider spacing stalls", s, 24);
      check("R5 UNIT reason", w, 3);
      drain();
   endtask

   task automatic t_priority();
      int s, w;
      drive(1'b1, UD, 5'd20, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      hold(UD, 5'd21, 1'b1, 5'd20, 1'b1, s, w);
      check("R8 RAW outranks UNIT", w, 1);
      check("R8 combined stall cycles", s, 24);
      drain();
   endtask

   task automatic t_pipe();
      drive(1'b1, UA, 5'd12, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R6 add 1 issues", int'(issue), 1);
      drive(1'b1, UA, 5'd13, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R6 add 2 issues", int'(issue), 1);
      drive(1'b1, UM, 5'd14, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R6 mul 1 issues", int'(issue), 1);
      drive(1'b1, UM, 5'd15, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R6 mul 2 issues", int'(issue), 1);
      for (int c = 4; c <= 10; c++) begin
         idle();
         case (c)
            4:  check("R9 add 1 done tag", done_valid ? int'(done_tag) : -1, 12);
            5:  check("R9 add 2 done tag", done_valid ? int'(done_tag) : -1, 13);
            9:  check("R9 mul 1 done tag", done_valid ? int'(done_tag) : -1, 14);
            10: check("R9 mul 2 done tag", done_valid ? int'(done_tag) : -1, 15);
            default: check("R9 no completion", int'(done_valid), 0);
         endcase
      end
      drain();
   endtask

   task automatic t_slot();
      int s, w;
      drive(1'b1, UM, 5'd16, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      idle();
      idle();
      hold(UA, 5'd17, 1'b1, 5'd0, 1'b0, s, w);
      check("R7 slot stall cycles", s, 1);
      check("R7 SLOT reason", w, 4);
      idle();
      idle();
      idle();
      check("R7 in-flight mul keeps its cycle", done_valid ? int'(done_tag) : -1, 16);
      idle();
      check("R7 held add completes one later", done_valid ? int'(done_tag) : -1, 17);
      drain();
   endtask

   task automatic t_src_enable();
      drive(1'b1, UA, 5'd18, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      drive(1'b1, UI, 5'd19, 1'b0, 5'd18, 1'b0, 5'd18, 1'b0);
      check("R10 disabled sources ignored", int'(issue), 1);
      idle();
      check("R9 no-write done tag", done_valid ? int'(done_tag) : -1, 19);
      check("R9 no-write done flag", int'(done_wr), 0);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_int_chain();
      t_raw(UA, 5'd2, 3);
      t_raw(UM, 5'd3, 6);
      t_raw(UD, 5'd4, 24);
      t_waw();
      t_div_busy();
      t_priority();
      t_pipe();
      t_slot();
      t_src_enable();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 5000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule